// File: doc/BRIEF.md
# Endpoint buffer window allocator

This block decides where each endpoint's packet buffer sits inside a shared dual-port packet RAM. Software programs each endpoint through a single register-style write port. A configuration write carries the allocate bit, the bank count, the size code, the direction and the transfer type. A separate write changes only the enable bit. A third kind of write clears the endpoint's data-lost flag. For every endpoint the block reports the base byte address, the window length, the allocated flag, the enable flag, the data-lost flag and the stored configuration.

Windows are meant to be allocated in ascending endpoint order. When an endpoint is allocated, its window is placed right after the window of the endpoint below it. When an endpoint is allocated or freed, only the next endpoint's window moves, and that window's contents are reported as lost. Windows further up keep their old addresses, even when this makes windows collide. The block reports such collisions, and windows that run past the end of the RAM, as per-endpoint flags. The USB protocol engine, the data path and the RAM itself sit outside this block.

Top module: `usb_ep_buf_alloc`

## Requirements
- R1: A configuration write (wr_kind 0) with wr_alloc=1 to an unallocated endpoint n sets alloc_o[n] after that clock edge. On the next edge base_o[n] becomes 0 if n is 0, becomes the end address (base plus length) of endpoint n-1 if n-1 is allocated, and becomes 0 otherwise.
- R2: The window length is (8 << size code) times the bank count. Bank code 0 means 1 bank, code 1 means 2 banks, and codes 2 and 3 mean 3 banks. Lengths therefore run from 8 to 3072 bytes.
- R3: When endpoint n is allocated while n+1 holds a window, the n+1 base moves to the new end address of n, and lost_o[n+1] is set.
- R4: Freeing endpoint n (configuration write with wr_alloc=0 to an allocated endpoint) sets base_o[n] to 0. If n+1 holds a window, its base moves down to the old base of n, and lost_o[n+1] is set.
- R5: Allocating or freeing endpoint n leaves the base of every endpoint from n+2 upwards unchanged.
- R6: An enable write (wr_kind 1) changes only enable_o of the addressed endpoint. Its allocated flag, bank code, size code, direction, type and base all keep their values.
- R7: A lost-clear write (wr_kind 2) clears lost_o of the addressed endpoint. Reallocating an endpoint also clears its own lost_o. Otherwise lost_o holds its value.
- R8: overlap_o[i] is set when endpoints i and i+1 are both allocated and their byte ranges intersect. overlap_o of the last endpoint is always 0.
- R9: overflow_o[i] is set when endpoint i is allocated and its base plus length exceeds RAM_BYTES.
- R10: After reset, every flag is 0, every base is 0, and every configuration field is 0, so each length reads 8.
- R11: Writes with wr_kind 3, and writes that address an endpoint index of NUM_EP or above, change nothing.
- R12: A configuration write with wr_alloc=1 to an endpoint that is already allocated updates its configuration fields but moves no window and changes no lost flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 configuration, 1 enable, 2 lost clear, 3 none |
| wr_ep | input | EPW | Addressed endpoint index |
| wr_alloc | input | 1 | Allocate bit of a configuration write |
| wr_enable | input | 1 | Enable bit of an enable write |
| wr_banks | input | 2 | Bank code |
| wr_size | input | 3 | Size code |
| wr_dir | input | 1 | Direction bit |
| wr_type | input | 2 | Transfer type |
| alloc_o | output | NUM_EP | Allocated flags |
| enable_o | output | NUM_EP | Enable flags |
| lost_o | output | NUM_EP | Data-lost flags |
| overlap_o | output | NUM_EP | Window i intersects window i+1 |
| overflow_o | output | NUM_EP | Window i ends beyond RAM_BYTES |
| base_o | output | NUM_EP*BW | Base byte addresses, endpoint i at bits i*BW |
| len_o | output | NUM_EP*BW | Window lengths in bytes |
| banks_o | output | NUM_EP*2 | Stored bank codes |
| size_o | output | NUM_EP*3 | Stored size codes |
| dir_o | output | NUM_EP | Stored direction bits |
| type_o | output | NUM_EP*2 | Stored transfer types |

EPW is ceil(log2(NUM_EP)). BW is ceil(log2(NUM_EP*3072+1)).

## Verification
The bench frees a middle endpoint and then reallocates it. This shows whether exactly one neighbour slides and whether the endpoint two places up stays where it was. A design that shifted every following window would move that endpoint and fail. A design that slid nothing would leave the neighbour in place and miss its lost flag. The bench also grows an allocated window in place to force an overlap, and stacks 3-bank 1024-byte windows past the end of RAM to force an overflow. A design that recomputed bases on every configuration write would remove the overlap, and one that compared against the wrong limit would miss the overflow. Random writes then mix out-of-range indices, no-op writes and enable toggles against a reference model, so that retained configuration and stale lost flags get caught.

// File: rtl/usb_bufalloc_pkg.sv
package usb_bufalloc_pkg;

   typedef enum logic [1:0] {
      WK_CFG = 2'd0,
      WK_ENA = 2'd1,
      WK_CLR = 2'd2,
      WK_NOP = 2'd3
   } wr_kind_e;

   localparam int unsigned LEN_W   = 12;
   localparam int unsigned MAX_LEN = 3072;

   typedef struct packed {
      logic       alloc;
      logic       enable;
      logic [1:0] banks;
      logic [2:0] size;
      logic       dir;
      logic [1:0] ttype;
   } ep_cfg_t;

   function automatic logic [LEN_W-1:0] win_len(input logic [1:0] banks,
                                                input logic [2:0] size);
      logic [LEN_W-1:0] unit;
      unit = LEN_W'(8) << size;
      case (banks)
         2'd0:    return unit;
         2'd1:    return unit << 1;
         default: return (unit << 1) + unit;
      endcase
   endfunction

endpackage

// File: rtl/bufalloc_slot.sv
module bufalloc_slot
   import usb_bufalloc_pkg::*;
#(
   parameter int unsigned BW = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  wr_kind_e          kind,
   input  ep_cfg_t           wr_cfg,
   output ep_cfg_t           cfg_q,
   output logic [BW-1:0]     len
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (hit) begin
         case (kind)
            WK_CFG: begin
               cfg_q.alloc <= wr_cfg.alloc;
               cfg_q.banks <= wr_cfg.banks;
               cfg_q.size  <= wr_cfg.size;
               cfg_q.dir   <= wr_cfg.dir;
               cfg_q.ttype <= wr_cfg.ttype;
            end
            WK_ENA:  cfg_q.enable <= wr_cfg.enable;
            default: ;
         endcase
      end
   end

   assign len = BW'(win_len(cfg_q.banks, cfg_q.size));

endmodule

// File: rtl/bufalloc_place.sv
module bufalloc_place #(
   parameter int unsigned NUM_EP = 6,
   parameter int unsigned EPW    = 3,
   parameter int unsigned BW     = 15
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          evt_valid,
   input  logic                          evt_ins,
   input  logic [EPW-1:0]                evt_ep,
   input  logic [NUM_EP-1:0]             alloc_i,
   input  logic [NUM_EP-1:0][BW-1:0]     len_i,
   input  logic [NUM_EP-1:0]             clr_i,
   output logic [NUM_EP-1:0][BW-1:0]     base_o,
   output logic [NUM_EP-1:0]             lost_o
);

   logic [NUM_EP-1:0][BW-1:0] ins_base;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_win
      logic          self_ins, self_rem, nb_ins, nb_rem;
      logic [BW-1:0] nb_base;

      assign self_ins = evt_valid &  evt_ins & (evt_ep == EPW'(i));
      assign self_rem = evt_valid & ~evt_ins & (evt_ep == EPW'(i));

      if (i == 0) begin : g_first
         assign ins_base[i] = '0;
         assign nb_ins      = 1'b0;
         assign nb_rem      = 1'b0;
         assign nb_base     = '0;
      end else begin : g_rest
         assign ins_base[i] = alloc_i[i-1] ? (base_o[i-1] + len_i[i-1]) : '0;
         assign nb_ins  = evt_valid &  evt_ins & (evt_ep == EPW'(i-1)) & alloc_i[i];
         assign nb_rem  = evt_valid & ~evt_ins & (evt_ep == EPW'(i-1)) & alloc_i[i];
         assign nb_base = nb_ins ? (ins_base[i-1] + len_i[i-1]) : base_o[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[i] <= '0;
            lost_o[i] <= 1'b0;
         end else begin
            if (self_ins)
               base_o[i] <= ins_base[i];
            else if (self_rem)
               base_o[i] <= '0;
            else if (nb_ins | nb_rem)
               base_o[i] <= nb_base;

            if (nb_ins | nb_rem)
               lost_o[i] <= 1'b1;
            else if (self_ins | clr_i[i])
               lost_o[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/bufalloc_guard.sv
module bufalloc_guard #(
   parameter int unsigned NUM_EP    = 6,
   parameter int unsigned BW        = 15,
   parameter int unsigned RAM_BYTES = 4096
) (
   input  logic [NUM_EP-1:0]          alloc_i,
   input  logic [NUM_EP-1:0][BW-1:0]  base_i,
   input  logic [NUM_EP-1:0][BW-1:0]  len_i,
   output logic [NUM_EP-1:0]          overlap_o,
   output logic [NUM_EP-1:0]          overflow_o
);

   logic [NUM_EP-1:0][BW:0] end_addr;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
      assign end_addr[i]   = {1'b0, base_i[i]} + {1'b0, len_i[i]};
      assign overflow_o[i] = alloc_i[i] && (32'(end_addr[i]) > 32'(RAM_BYTES));

      if (i == NUM_EP - 1) begin : g_last
         assign overlap_o[i] = 1'b0;
      end else begin : g_pair
         assign overlap_o[i] = alloc_i[i] && alloc_i[i+1]
                               && ({1'b0, base_i[i]}   < end_addr[i+1])
                               && ({1'b0, base_i[i+1]} < end_addr[i]);
      end
   end

endmodule

// File: rtl/usb_ep_buf_alloc.sv
module usb_ep_buf_alloc
   import usb_bufalloc_pkg::*;
#(
   parameter int unsigned NUM_EP    = 6,
   parameter int unsigned RAM_BYTES = 4096,
   localparam int unsigned EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
   localparam int unsigned BW       = $clog2(NUM_EP * MAX_LEN + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [1:0]            wr_kind,
   input  logic [EPW-1:0]        wr_ep,
   input  logic                  wr_alloc,
   input  logic                  wr_enable,
   input  logic [1:0]            wr_banks,
   input  logic [2:0]            wr_size,
   input  logic                  wr_dir,
   input  logic [1:0]            wr_type,
   output logic [NUM_EP-1:0]     alloc_o,
   output logic [NUM_EP-1:0]     enable_o,
   output logic [NUM_EP-1:0]     lost_o,
   output logic [NUM_EP-1:0]     overlap_o,
   output logic [NUM_EP-1:0]     overflow_o,
   output logic [NUM_EP*BW-1:0]  base_o,
   output logic [NUM_EP*BW-1:0]  len_o,
   output logic [NUM_EP*2-1:0]   banks_o,
   output logic [NUM_EP*3-1:0]   size_o,
   output logic [NUM_EP-1:0]     dir_o,
   output logic [NUM_EP*2-1:0]   type_o
);

   if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_num_ep
      $error("usb_ep_buf_alloc: NUM_EP must lie in 2..16");
   end
   if (RAM_BYTES < 64) begin : g_bad_ram
      $error("usb_ep_buf_alloc: RAM_BYTES must be at least 64");
   end

   wr_kind_e                   kind;
   ep_cfg_t                    wr_cfg;
   ep_cfg_t [NUM_EP-1:0]       cfg_q;
   logic [NUM_EP-1:0]          hit, clr, toggles;
   logic [NUM_EP-1:0][BW-1:0]  len_w, base_w;

   logic                       evt_valid_q, evt_ins_q;
   logic [EPW-1:0]             evt_ep_q;

   assign kind   = wr_kind_e'(wr_kind);
   assign wr_cfg = '{alloc: wr_alloc, enable: wr_enable, banks: wr_banks,
                     size: wr_size, dir: wr_dir, ttype: wr_type};

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      assign hit[i]     = wr_valid && (wr_ep == EPW'(i));
      assign clr[i]     = hit[i] && (kind == WK_CLR);
      assign toggles[i] = hit[i] && (kind == WK_CFG) && (wr_alloc != cfg_q[i].alloc);

      bufalloc_slot #(.BW(BW)) slot_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (hit[i]),
         .kind   (kind),
         .wr_cfg (wr_cfg),
         .cfg_q  (cfg_q[i]),
         .len    (len_w[i])
      );

      assign alloc_o[i]           = cfg_q[i].alloc;
      assign enable_o[i]          = cfg_q[i].enable;
      assign dir_o[i]             = cfg_q[i].dir;
      assign banks_o[i*2 +: 2]    = cfg_q[i].banks;
      assign size_o[i*3 +: 3]     = cfg_q[i].size;
      assign type_o[i*2 +: 2]     = cfg_q[i].ttype;
      assign base_o[i*BW +: BW]   = base_w[i];
      assign len_o[i*BW +: BW]    = len_w[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid_q <= 1'b0;
         evt_ins_q   <= 1'b0;
         evt_ep_q    <= '0;
      end else begin
         evt_valid_q <= |toggles;
         evt_ins_q   <= wr_alloc;
         evt_ep_q    <= wr_ep;
      end
   end

   bufalloc_place #(.NUM_EP(NUM_EP), .EPW(EPW), .BW(BW)) place_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid_q),
      .evt_ins   (evt_ins_q),
      .evt_ep    (evt_ep_q),
      .alloc_i   (alloc_o),
      .len_i     (len_w),
      .clr_i     (clr),
      .base_o    (base_w),
      .lost_o    (lost_o)
   );

   bufalloc_guard #(.NUM_EP(NUM_EP), .BW(BW), .RAM_BYTES(RAM_BYTES)) guard_i (
      .alloc_i    (alloc_o),
      .base_i     (base_w),
      .len_i      (len_w),
      .overlap_o  (overlap_o),
      .overflow_o (overflow_o)
   );

endmodule

// File: rtl/bufalloc_sva.sv
module bufalloc_sva #(
   parameter int unsigned NUM_EP = 6,
   parameter int unsigned EPW    = 3,
   parameter int unsigned BW     = 15
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_EP-1:0]     alloc,
   input logic [NUM_EP-1:0]     enable,
   input logic [NUM_EP-1:0]     lost,
   input logic [NUM_EP-1:0]     overlap,
   input logic [NUM_EP-1:0]     overflow,
   input logic [NUM_EP*BW-1:0]  base,
   input logic [NUM_EP*BW-1:0]  len,
   input logic [NUM_EP*2-1:0]   banks,
   input logic [NUM_EP*3-1:0]   size,
   input logic                  evt_valid,
   input logic [EPW-1:0]        evt_ep
);

   assert_ep0_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
      base[BW-1:0] == '0);

   assert_no_lost0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lost[0]);

   assert_last_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !overlap[NUM_EP-1]);

   for (genvar i = 0; i < NUM_EP; i++) begin : g_a
      assert_len_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
         len[i*BW +: BW] >= BW'(8));

      assert_ena_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $changed(enable[i]) |-> $stable(alloc[i]) && $stable(size[i*3 +: 3])
                                 && $stable(banks[i*2 +: 2]));

      assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
         overflow[i] |-> alloc[i]);

      if (i > 0) begin : g_nb
         assert_lost_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lost[i]) |-> $past(evt_valid) && ($past(evt_ep) == EPW'(i-1)));
      end

      if (i < NUM_EP - 1) begin : g_pair
         assert_overlap_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
            overlap[i] |-> alloc[i] && alloc[i+1]);
      end

      if (i > 1) begin : g_far
         assert_far_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && evt_ep == EPW'(i-2)) |=> $stable(base[i*BW +: BW]));
      end
   end

endmodule

bind usb_ep_buf_alloc bufalloc_sva #(.NUM_EP(NUM_EP), .EPW(EPW), .BW(BW)) sva_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .alloc     (alloc_o),
   .enable    (enable_o),
   .lost      (lost_o),
   .overlap   (overlap_o),
   .overflow  (overflow_o),
   .base      (base_o),
   .len       (len_o),
   .banks     (banks_o),
   .size      (size_o),
   .evt_valid (evt_valid_q),
   .evt_ep    (evt_ep_q)
);

// File: tb/usb_ep_buf_alloc_tb_top.sv
`timescale 1ns/1ps
module usb_ep_buf_alloc_tb_top;

   localparam int N   = 6;
   localparam int RAM = 4096;
   localparam int EPW = 3;
   localparam int BW  = $clog2(N * 3072 + 1);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic            wr_valid, wr_alloc, wr_enable, wr_dir;
   logic [1:0]      wr_kind, wr_banks, wr_type;
   logic [EPW-1:0]  wr_ep;
   logic [2:0]      wr_size;
   logic [N-1:0]    alloc_o, enable_o, lost_o, overlap_o, overflow_o, dir_o;
   logic [N*BW-1:0] base_o, len_o;
   logic [N*2-1:0]  banks_o, type_o;
   logic [N*3-1:0]  size_o;

   usb_ep_buf_alloc #(.NUM_EP(N), .RAM_BYTES(RAM)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_ep(wr_ep),
      .wr_alloc(wr_alloc), .wr_enable(wr_enable), .wr_banks(wr_banks), .wr_size(wr_size),
      .wr_dir(wr_dir), .wr_type(wr_type), .alloc_o(alloc_o), .enable_o(enable_o),
      .lost_o(lost_o), .overlap_o(overlap_o), .overflow_o(overflow_o), .base_o(base_o),
      .len_o(len_o), .banks_o(banks_o), .size_o(size_o), .dir_o(dir_o), .type_o(type_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int m_alloc[N], m_ena[N], m_lost[N], m_base[N];
   int m_banks[N], m_size[N], m_dir[N], m_type[N];

   function automatic int f_len(int b, int s);
      int u = 8 << s;
      if (b == 0) return u;
      if (b == 1) return 2 * u;
      return 3 * u;
   endfunction

   function automatic int f_ovf(int i);
      return (m_alloc[i] != 0 && m_base[i] + f_len(m_banks[i], m_size[i]) > RAM) ? 1 : 0;
   endfunction

   function automatic int f_ovl(int i);
      int ea, eb;
      if (i >= N - 1 || m_alloc[i] == 0 || m_alloc[i+1] == 0) return 0;
      ea = m_base[i] + f_len(m_banks[i], m_size[i]);
      eb = m_base[i+1] + f_len(m_banks[i+1], m_size[i+1]);
      return (m_base[i] < eb && m_base[i+1] < ea) ? 1 : 0;
   endfunction

   task automatic cmp(string r, string what, int i, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s ep%0d: actual=%0d expected=%0d", r, what, i, act, exp);
      end
   endtask

   task automatic check_all(string r);
      for (int i = 0; i < N; i++) begin
         cmp(r, "alloc",    i, int'(alloc_o[i]),            m_alloc[i]);
         cmp(r, "enable",   i, int'(enable_o[i]),           m_ena[i]);
         cmp(r, "lost",     i, int'(lost_o[i]),             m_lost[i]);
         cmp(r, "base",     i, int'(base_o[i*BW +: BW]),    m_base[i]);
         cmp("R2", "len",   i, int'(len_o[i*BW +: BW]),     f_len(m_banks[i], m_size[i]));
         cmp(r, "banks",    i, int'(banks_o[i*2 +: 2]),     m_banks[i]);
         cmp(r, "size",     i, int'(size_o[i*3 +: 3]),      m_size[i]);
         cmp(r, "dir",      i, int'(dir_o[i]),              m_dir[i]);
         cmp(r, "type",     i, int'(type_o[i*2 +: 2]),      m_type[i]);
         cmp("R8", "overlap",  i, int'(overlap_o[i]),       f_ovl(i));
         cmp("R9", "overflow", i, int'(overflow_o[i]),      f_ovf(i));
      end
   endtask

   task automatic model_apply(int k, int ep, int a, int e, int b, int s, int d, int t);
      int old, nb;
      if (ep >= N || k == 3) return;
      if (k == 1) begin m_ena[ep] = e; return; end
      if (k == 2) begin m_lost[ep] = 0; return; end
      old = m_alloc[ep];
      m_alloc[ep] = a; m_banks[ep] = b; m_size[ep] = s; m_dir[ep] = d; m_type[ep] = t;
      if (old == 0 && a != 0) begin
         nb = 0;
         if (ep > 0 && m_alloc[ep-1] != 0)
            nb = m_base[ep-1] + f_len(m_banks[ep-1], m_size[ep-1]);
         m_base[ep] = nb;
         m_lost[ep] = 0;
         if (ep + 1 < N && m_alloc[ep+1] != 0) begin
            m_base[ep+1] = nb + f_len(b, s);
            m_lost[ep+1] = 1;
         end
      end else if (old != 0 && a == 0) begin
         if (ep + 1 < N && m_alloc[ep+1] != 0) begin
            m_base[ep+1] = m_base[ep];
            m_lost[ep+1] = 1;
         end
         m_base[ep] = 0;
      end
   endtask

   task automatic drive(int k, int ep, int a, int e, int b, int s, int d, int t);
      @(negedge clk);
      wr_valid = 1'b1; wr_kind = 2'(k); wr_ep = EPW'(ep); wr_alloc = 1'(a);
      wr_enable = 1'(e); wr_banks = 2'(b); wr_size = 3'(s); wr_dir = 1'(d); wr_type = 2'(t);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_write(int k, int ep, int a, int e, int b, int s, int d, int t);
      drive(k, ep, a, e, b, s, d, t);
      @(negedge clk);
      model_apply(k, ep, a, e, b, s, d, t);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual=timeout expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_alloc[i] = 0; m_ena[i] = 0; m_lost[i] = 0; m_base[i] = 0;
         m_banks[i] = 0; m_size[i] = 0; m_dir[i] = 0; m_type[i] = 0;
      end
      wr_valid = 0; wr_kind = 0; wr_ep = 0; wr_alloc = 0; wr_enable = 0;
      wr_banks = 0; wr_size = 0; wr_dir = 0; wr_type = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10");

      // R1: build the chain 0..3
      do_write(0, 0, 1, 0, 0, 3, 1, 2);
      check_all("R1");
      drive(0, 1, 1, 0, 1, 2, 0, 1);
      cmp("R1", "alloc before base", 1, int'(alloc_o[1]), 1);
      cmp("R1", "base not yet moved", 1, int'(base_o[1*BW +: BW]), 0);
      @(negedge clk);
      model_apply(0, 1, 1, 0, 1, 2, 0, 1);
      check_all("R1");
      do_write(0, 2, 1, 0, 2, 1, 1, 3);
      check_all("R1");
      do_write(0, 3, 1, 0, 0, 0, 0, 0);
      check_all("R1");
      cmp("R1", "base ep3 directed", 3, int'(base_o[3*BW +: BW]), 176);

      // R4 / R5: free ep1
      do_write(0, 1, 0, 0, 1, 2, 0, 1);
      check_all("R4");
      cmp("R4", "ep2 slid down", 2, int'(base_o[2*BW +: BW]), 64);
      cmp("R5", "ep3 unmoved", 3, int'(base_o[3*BW +: BW]), 176);

      // R7: lost clear
      do_write(2, 2, 0, 0, 0, 0, 0, 0);
      check_all("R7");

      // R3 / R5: reinsert ep1
      do_write(0, 1, 1, 0, 1, 2, 0, 1);
      check_all("R3");
      cmp("R3", "ep2 slid up", 2, int'(base_o[2*BW +: BW]), 128);
      cmp("R3", "ep2 lost", 2, int'(lost_o[2]), 1);

      // R7: reallocation clears own lost flag
      do_write(0, 2, 0, 0, 2, 1, 1, 3);
      check_all("R4");
      do_write(0, 2, 1, 0, 2, 1, 1, 3);
      check_all("R7");
      cmp("R7", "ep2 lost cleared by realloc", 2, int'(lost_o[2]), 0);

      // R6: enable toggles keep configuration
      do_write(1, 1, 0, 1, 0, 0, 0, 0);
      check_all("R6");
      do_write(1, 1, 0, 0, 3, 7, 1, 3);
      check_all("R6");

      // R11: out-of-range index and no-op kind
      do_write(0, 7, 1, 1, 2, 7, 1, 3);
      check_all("R11");
      do_write(3, 2, 0, 1, 3, 7, 0, 0);
      check_all("R11");

      // R12 / R8: grow ep0 in place
      do_write(0, 0, 1, 0, 0, 4, 1, 2);
      check_all("R12");
      cmp("R8", "ep0/ep1 overlap", 0, int'(overlap_o[0]), 1);

      // R9: run past the RAM end
      do_write(0, 4, 1, 0, 2, 7, 0, 0);
      check_all("R9");
      do_write(0, 5, 1, 0, 2, 7, 0, 0);
      check_all("R9");
      cmp("R9", "ep5 overflow", 5, int'(overflow_o[5]), 1);

      // random phase
      void'($urandom(32'h5eed_0042));
      for (int n = 0; n < 400; n++) begin
         int k, ep;
         k  = int'($urandom % 8);
         k  = (k < 5) ? 0 : k - 4;
         ep = int'($urandom % 8);
         do_write(k, ep, int'($urandom % 2), int'($urandom % 2), int'($urandom % 4),
                  int'($urandom % 8), int'($urandom % 2), int'($urandom % 4));
         if (ep >= N || k == 3) check_all("R11");
         else if (k == 1)       check_all("R6");
         else if (k == 2)       check_all("R7");
         else                   check_all("R1");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule